// File: doc/BRIEF.md
# Wrapped-Order Line Refill Controller

This block services a read miss on a multi-word cache line by asking memory for the whole line as one burst. The burst starts with the word the CPU asked for and wraps around the line. The controller keeps a single line buffer with a tag and one valid flag per word. When a read misses, it records the new tag, clears every word flag and sends one burst request that carries the full missed address. Memory then returns one word per beat. Beats may come back to back or with idle cycles between them.

The requested word goes to the CPU in the same cycle it appears on the memory port, so the CPU stall ends before the line is complete. The rest of the line keeps filling in the background. While the fill runs, a read of a word that has already arrived hits at once. A read of a word in the same line that has not arrived yet waits for that word's beat. A read of any other line waits until the whole fill is done and then starts a fresh fill.

Top module: `cwf_line_fill_ctrl`

## Requirements
- R1: After reset no line is held, `mem_req_o` is low, and `cpu_stall_o` is low while `cpu_req_i` is low.
- R2: A read that misses while no fill is running raises `cpu_stall_o` in the same cycle. In the next cycle it pulses `mem_req_o` high for exactly one cycle, with `mem_addr_o` equal to the missed address (the line number in the upper bits, the word offset in the low 3 bits).
- R3: The k-th beat of a fill (k = 0..7) is stored as word (start offset + k) mod 8 of the line.
- R4: In the cycle the missed word's beat arrives (`mem_rvalid_i` high), `cpu_stall_o` is low and `cpu_rdata_o` equals `mem_rdata_i`.
- R5: During a fill, a read of a word of the filling line whose beat has already arrived returns the stored word with `cpu_stall_o` low.
- R6: During a fill, a read of a word of the filling line that has not arrived yet stalls until the cycle that word's beat arrives, and the beat is forwarded in that cycle.
- R7: During a fill, a read of a different line stalls until the eighth beat has been taken, and then starts a new fill for that line.
- R8: After the eighth beat, all 8 words of the line read back with no stall. A `mem_rvalid_i` pulse while no fill is running changes no stored word.
- R9: Reads of a completely filled line produce no `mem_req_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU read request, held until not stalled |
| cpu_addr_i | input | ADDR_W | CPU word address (line number and word offset) |
| cpu_stall_o | output | 1 | Request cannot be served in this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid when requested and not stalled |
| mem_req_o | output | 1 | One-cycle burst request |
| mem_addr_o | output | ADDR_W | Missed address; the burst starts at its word |
| mem_rvalid_i | input | 1 | A burst beat is present |
| mem_rdata_i | input | DATA_W | Burst beat data |

## Verification
The hardest case to reach is a read that lands inside a running fill: one word that has already arrived, one that is still pending past the wrap point, and one in a foreign line. All three must be issued while beats are still coming in. The stimulus slows the bench memory down to one beat every few cycles. It then issues these reads back to back while the burst is in flight, so each class is met with the fill only partly done. A reference model then predicts, cycle by cycle, the stall, the forwarded data and the moment the next request goes out.

// File: rtl/cwf_fill_pkg.sv
package cwf_fill_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;
endpackage

// File: rtl/cwf_fill_seq.sv
// Burst sequencer: tracks where the next beat lands and how many beats have landed.
module cwf_fill_seq
   import cwf_fill_pkg::*;
#(
   parameter int WORDS = 8,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OFF_W-1:0] start_off_i,
   input  logic             beat_i,
   output logic             active_o,
   output logic [OFF_W-1:0] ptr_o,
   output logic [OFF_W:0]   cnt_o
);
   fill_state_e      state_q;
   logic [OFF_W-1:0] ptr_q;
   logic [OFF_W:0]   cnt_q;
   logic             take;
   logic             last;

   assign take = (state_q == FS_FILL) && beat_i;
   assign last = (cnt_q == (OFF_W+1)'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         ptr_q   <= '0;
         cnt_q   <= '0;
      end else if (start_i && state_q == FS_IDLE) begin
         state_q <= FS_FILL;
         ptr_q   <= start_off_i;
         cnt_q   <= '0;
      end else if (take) begin
         ptr_q <= ptr_q + 1'b1;   // power-of-two line: wraps by overflow
         cnt_q <= cnt_q + 1'b1;
         if (last) state_q <= FS_IDLE;
      end
   end

   assign active_o = (state_q == FS_FILL);
   assign ptr_o    = ptr_q;
   assign cnt_o    = cnt_q;

   // R3: a running fill never counts past the line length
   a_r3_cnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (cnt_q < (OFF_W+1)'(WORDS)));
   // R3: successive beats advance the landing slot by one, wrapping
   a_r3_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !last) |=> (ptr_q == OFF_W'($past(ptr_q) + 1'b1)));
endmodule

// File: rtl/cwf_line_store.sv
// Per-word data and valid flags of the line buffer.
module cwf_line_store #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_i,
   input  logic [OFF_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [OFF_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic [WORDS-1:0]  valid_o
);
   logic [DATA_W-1:0] word_q [WORDS];
   logic [WORDS-1:0]  vld_q;

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      logic hit_wr;
      assign hit_wr = wr_i && (wr_idx_i == OFF_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld_q[gi] <= 1'b0;
         else if (clear_i) vld_q[gi] <= 1'b0;
         else if (hit_wr)  vld_q[gi] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit_wr) word_q[gi] <= wr_data_i;
      end
   end

   assign rd_data_o  = word_q[rd_idx_i];
   assign rd_valid_o = vld_q[rd_idx_i];
   assign valid_o    = vld_q;

   // R8: a slot that is written reads as present afterwards
   a_r8_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clear_i) |=> vld_q[$past(wr_idx_i)]);
endmodule

// File: rtl/cwf_hit_unit.sv
// Decides hit, forward and stall for the CPU port.
module cwf_hit_unit #(
   parameter int DATA_W = 32
) (
   input  logic              req_i,
   input  logic              line_match_i,
   input  logic              word_present_i,
   input  logic              fwd_i,
   input  logic [DATA_W-1:0] stored_i,
   input  logic [DATA_W-1:0] beat_i,
   output logic              hit_o,
   output logic              stall_o,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      hit_o   = req_i && line_match_i && (word_present_i || fwd_i);
      stall_o = req_i && !hit_o;
      data_o  = fwd_i ? beat_i : stored_i;
   end
endmodule

// File: rtl/cwf_line_fill_ctrl.sv
module cwf_line_fill_ctrl #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   localparam int OFF_W = $clog2(WORDS),
   localparam int TAG_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   output logic              cpu_stall_o,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the word offset width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [TAG_W-1:0]  req_line;
   logic [OFF_W-1:0]  req_off;
   logic [TAG_W-1:0]  tag_q;
   logic              have_q;
   logic              mreq_q;
   logic [ADDR_W-1:0] maddr_q;
   logic              active;
   logic [OFF_W-1:0]  ptr;
   logic [OFF_W:0]    cnt;
   logic              beat;
   logic              line_match;
   logic              fwd;
   logic              start;
   logic              hit;
   logic              present;
   logic [DATA_W-1:0] stored;
   logic [WORDS-1:0]  valid;

   assign req_line   = cpu_addr_i[ADDR_W-1:OFF_W];
   assign req_off    = cpu_addr_i[OFF_W-1:0];
   assign line_match = have_q && (req_line == tag_q);
   assign beat       = active && mem_rvalid_i;
   assign fwd        = beat && line_match && (req_off == ptr);
   assign start      = cpu_req_i && !hit && !active;

   cwf_fill_seq #(.WORDS(WORDS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .start_off_i(req_off),
      .beat_i     (mem_rvalid_i),
      .active_o   (active),
      .ptr_o      (ptr),
      .cnt_o      (cnt)
   );

   cwf_line_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start),
      .wr_i      (beat),
      .wr_idx_i  (ptr),
      .wr_data_i (mem_rdata_i),
      .rd_idx_i  (req_off),
      .rd_data_o (stored),
      .rd_valid_o(present),
      .valid_o   (valid)
   );

   cwf_hit_unit #(.DATA_W(DATA_W)) u_hit (
      .req_i         (cpu_req_i),
      .line_match_i  (line_match),
      .word_present_i(present),
      .fwd_i         (fwd),
      .stored_i      (stored),
      .beat_i        (mem_rdata_i),
      .hit_o         (hit),
      .stall_o       (cpu_stall_o),
      .data_o        (cpu_rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q   <= '0;
         have_q  <= 1'b0;
         mreq_q  <= 1'b0;
         maddr_q <= '0;
      end else begin
         mreq_q <= start;
         if (start) begin
            tag_q   <= req_line;
            have_q  <= 1'b1;
            maddr_q <= cpu_addr_i;
         end
      end
   end

   assign mem_req_o  = mreq_q;
   assign mem_addr_o = maddr_q;

   // R2: the burst request is a single-cycle pulse
   a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);
   // R2: the request goes out with every word flag of the line cleared
   a_r2_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (valid == '0));
   // R3: the word flags present always match the beats taken
   a_r3_flags_track_beats: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ($countones(valid) == int'(cnt)));
   // R8: the line is entirely present when a fill ends
   a_r8_full_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> (&valid));
   // R7: a served request always belongs to the held line
   a_r7_served_same_line: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_i && !cpu_stall_o) |-> (have_q && req_line == tag_q));
   // R9: no new burst while a fill is running
   a_r9_no_req_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !$past(start)) |-> !mem_req_o);
endmodule

// File: tb/cwf_line_fill_ctrl_tb.sv
module cwf_line_fill_ctrl_tb_top;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_i = 1'b0;
   logic [AW-1:0] cpu_addr_i = '0;
   logic          cpu_stall_o;
   logic [DW-1:0] cpu_rdata_o;
   logic          mem_req_o;
   logic [AW-1:0] mem_addr_o;
   logic          mem_rvalid_i = 1'b0;
   logic [DW-1:0] mem_rdata_i = '0;

   always #10 clk = ~clk;

   cwf_line_fill_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i),
      .cpu_stall_o(cpu_stall_o), .cpu_rdata_o(cpu_rdata_o),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   int n_cyc = 0;
   string tag_now = "R1";

   // reference model state
   int        m_tag = 0;
   bit        m_have = 0;
   bit [7:0]  m_valid = '0;
   logic [DW-1:0] m_data [8];
   bit        m_fill = 0;
   int        m_ptr = 0;
   int        m_cnt = 0;
   bit        m_mreq = 0;
   int        m_maddr = 0;
   bit        last_hit = 0;

   // bench memory
   logic [DW-1:0] beat_q [$];
   int  gap_len = 0;
   int  gap_cnt = 0;
   bit  spurious = 0;

   function automatic logic [DW-1:0] beat_val(int line, int word);
      return DW'(32'h3C00_0000 + line * 32'h101 + word * 32'h11);
   endfunction

   task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag_now, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic cycle(bit req, int addr);
      int  line, w;
      bit  mrv, fwd, hit;
      logic [DW-1:0] mrd;
      @(negedge clk);
      n_cyc++;
      if (n_cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", n_cyc);
         finish_run();
      end
      mrv = 0; mrd = '0;
      if (beat_q.size() > 0 && gap_cnt == 0) begin
         mrv = 1; mrd = beat_q.pop_front(); gap_cnt = gap_len;
      end else begin
         if (gap_cnt > 0) gap_cnt--;
         if (spurious && beat_q.size() == 0) begin mrv = 1; mrd = 32'hDEAD_BEEF; end
      end
      cpu_req_i = req; cpu_addr_i = AW'(addr);
      mem_rvalid_i = mrv; mem_rdata_i = mrd;
      #8;
      line = addr >> 3; w = addr & 7;
      fwd = m_fill && mrv && m_have && line == m_tag && w == m_ptr;
      hit = req && m_have && line == m_tag && (m_valid[w] || fwd);
      chk(cpu_stall_o == (req && !hit), "stall", DW'(cpu_stall_o), DW'(req && !hit));
      if (hit) chk(cpu_rdata_o == (fwd ? mrd : m_data[w]), "rdata", cpu_rdata_o, fwd ? mrd : m_data[w]);
      chk(mem_req_o == m_mreq, "mem_req", DW'(mem_req_o), DW'(m_mreq));
      if (m_mreq) begin
         chk(mem_addr_o == AW'(m_maddr), "mem_addr", DW'(mem_addr_o), DW'(m_maddr));
         for (int k = 0; k < 8; k++)
            beat_q.push_back(beat_val(m_maddr >> 3, ((m_maddr & 7) + k) % 8));
      end
      last_hit = hit;
      m_mreq = 0;
      if (m_fill && mrv) begin
         m_data[m_ptr] = mrd; m_valid[m_ptr] = 1;
         m_ptr = (m_ptr + 1) % 8; m_cnt++;
         if (m_cnt == 8) m_fill = 0;
      end else if (!m_fill && req && !hit) begin
         m_tag = line; m_have = 1; m_valid = '0; m_ptr = w; m_cnt = 0;
         m_fill = 1; m_mreq = 1; m_maddr = addr;
      end
   endtask

   task automatic access(int line, int w);
      do cycle(1'b1, line * 8 + w); while (!last_hit);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tag_now = "R1"; idle(4);                       // R1 reset state
      tag_now = "R2"; gap_len = 0; access(5, 3);     // R2 request, R4 forward
      tag_now = "R4"; idle(10);
      tag_now = "R3";                                // R3 wrapped placement
      for (int w = 0; w < 8; w++) access(5, w);
      tag_now = "R6"; gap_len = 3; access(9, 6);
      access(9, 1);                                  // R6 waits past the wrap
      tag_now = "R5"; access(9, 7);                  // R5 already present
      tag_now = "R7"; access(12, 0);                 // R7 foreign line
      idle(40);
      tag_now = "R8"; spurious = 1; idle(5); spurious = 0;
      for (int w = 0; w < 8; w++) access(12, w);     // R8 full line intact
      tag_now = "R9"; access(12, 5); idle(3);        // R9 no traffic
      tag_now = "R3"; gap_len = 1; access(3, 7);     // start at last word
      access(3, 0);
      idle(30);
      for (int w = 0; w < 8; w++) access(3, w);
      finish_run();
   end
endmodule